// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core (Nine-Instruction Subset)

This core executes one instruction per clock cycle from a private instruction memory and keeps its data in a separate private data memory. The supported instructions are five register-to-register operations (add, sub, and, or, set-less-than), load word, store word, branch-if-equal and an absolute jump. Every other encoding is a no-op: it only moves the program counter to the next word.

While reset is held, a load port writes 32-bit words into either memory. This is how a test environment places a program and its initial data. When reset is released, the core fetches from address 0.

Debug outputs show the address of the instruction being executed and the register write that will happen on the coming clock edge. From these an observer can follow execution one instruction at a time.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0, and `dbg_we` stays low. When `ld_en` is also high, `ld_data` is written to word `ld_addr` of the instruction memory (`ld_dmem`=0) or of the data memory (`ld_dmem`=1).
- R2: Instructions with op[31:26]=0x00 read registers rs[25:21] and rt[20:16] and write register rd[15:11] with the result. The function code in bits [5:0] selects the operation: 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). Add and sub wrap modulo 2^32, and overflow is ignored.
- R3: Both register read ports are combinational and return the value held before the edge. An instruction that reads and writes the same register uses the old value.
- R4: Load word (op 0x23) forms the address as rs plus the sign-extended immediate in bits [15:0]. It selects the data word with address bits [9:2] and writes that word to register rt.
- R5: Store word (op 0x2B) writes the value of rt to the word at the same kind of address, and a later load of that word returns it. The data memory read strobe and write strobe are never high together.
- R6: Branch-if-equal (op 0x04) sets the next PC to PC+4+(sign-extended immediate shifted left by 2) when rs equals rt, and to PC+4 otherwise.
- R7: Jump (op 0x02) sets the next PC to {PC+4 bits [31:28], bits [25:0], 2'b00}.
- R8: Register 0 always reads as zero. A write to it leaves it unchanged and is not flagged on `dbg_we`.
- R9: Any other op code, and any function code not listed in R2, writes no register and no memory and advances the PC by 4.
- R10: `dbg_pc` equals the PC of the instruction now executing. `dbg_we`, `dbg_waddr` and `dbg_wdata` describe the register write performed at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; loading is allowed only while it is high |
| ld_en | input | 1 | Load strobe for the memory load port |
| ld_dmem | input | 1 | Load target: 0 selects instruction memory, 1 selects data memory |
| ld_addr | input | 8 | Word index written by the load port |
| ld_data | input | 32 | Word written by the load port |
| dbg_pc | output | 32 | PC of the instruction being executed |
| dbg_we | output | 1 | A nonzero register is written at the next edge |
| dbg_waddr | output | 5 | Destination register of that write |
| dbg_wdata | output | 32 | Value of that write |

## Verification
All results of an instruction are due in the cycle that instruction is fetched. The register write value and destination appear on the debug outputs in that same cycle, with no delay. The new PC shows on `dbg_pc` one edge later. A store is confirmed by a later load whose write-back value is visible on the debug outputs.

The bench therefore steps a behavioural instruction-level model once per clock. It compares the model against the debug outputs 1 ns after each falling edge, while the core sits between edges. It then advances the model to the state the next rising edge will produce.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_en,
  input  logic        ld_dmem,
  input  logic [7:0]  ld_addr,
  input  logic [31:0] ld_data,
  output logic [31:0] dbg_pc,
  output logic        dbg_we,
  output logic [4:0]  dbg_waddr,
  output logic [31:0] dbg_wdata
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  localparam logic [5:0] OP_RT = 6'h00, OP_LW = 6'h23, OP_SW = 6'h2B,
                         OP_BEQ = 6'h04, OP_J = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24,
                         FN_OR = 6'h25, FN_SLT = 6'h2A;

  typedef enum logic [2:0] {A_ADD, A_SUB, A_AND, A_OR, A_SLT} alu_t;

  logic [31:0] pc, pc4, pc_next, instr;
  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf   [32];

  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, wa;
  logic [31:0] simm, rd1, rd2, alu_b, alu_y, dq, wd;
  logic        reg_we, reg_dst, use_imm, mem_rd, mem_wr, mem_to_reg;
  logic        is_beq, is_j, illegal, zero;
  alu_t        alu_op;

  assign instr = imem[pc[IAW+1:2]];
  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign fn    = instr[5:0];
  assign simm  = {{16{instr[15]}}, instr[15:0]};
  assign pc4   = pc + 32'd4;

  always_comb begin
    reg_we = 1'b0; reg_dst = 1'b0; use_imm = 1'b0; mem_rd = 1'b0;
    mem_wr = 1'b0; mem_to_reg = 1'b0; is_beq = 1'b0; is_j = 1'b0;
    illegal = 1'b0; alu_op = A_ADD;
    case (op)
      OP_RT: begin
        reg_we = 1'b1; reg_dst = 1'b1;
        case (fn)
          FN_ADD: alu_op = A_ADD;
          FN_SUB: alu_op = A_SUB;
          FN_AND: alu_op = A_AND;
          FN_OR:  alu_op = A_OR;
          FN_SLT: alu_op = A_SLT;
          default: begin reg_we = 1'b0; illegal = 1'b1; end
        endcase
      end
      OP_LW:  begin reg_we = 1'b1; use_imm = 1'b1; mem_rd = 1'b1; mem_to_reg = 1'b1; end
      OP_SW:  begin use_imm = 1'b1; mem_wr = 1'b1; end
      OP_BEQ: begin is_beq = 1'b1; alu_op = A_SUB; end
      OP_J:   is_j = 1'b1;
      default: illegal = 1'b1;
    endcase
  end

  assign rd1   = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign rd2   = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b = use_imm ? simm : rd2;

  always_comb begin
    case (alu_op)
      A_SUB:   alu_y = rd1 - alu_b;
      A_AND:   alu_y = rd1 & alu_b;
      A_OR:    alu_y = rd1 | alu_b;
      A_SLT:   alu_y = {31'd0, $signed(rd1) < $signed(alu_b)};
      default: alu_y = rd1 + alu_b;
    endcase
  end
  assign zero = (alu_y == 32'd0);

  assign dq = mem_rd ? dmem[alu_y[DAW+1:2]] : 32'd0;
  assign wa = reg_dst ? rd : rt;
  assign wd = mem_to_reg ? dq : alu_y;

  always_comb begin
    if (is_j)                pc_next = {pc4[31:28], instr[25:0], 2'b00};
    else if (is_beq && zero) pc_next = pc4 + {simm[29:0], 2'b00};
    else                     pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (reg_we && wa != 5'd0) begin
      rf[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en && !ld_dmem) imem[ld_addr[IAW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst && ld_en && ld_dmem)  dmem[ld_addr[DAW-1:0]] <= ld_data;
    else if (!rst && mem_wr)      dmem[alu_y[DAW+1:2]] <= rd2;
  end

  assign dbg_pc    = pc;
  assign dbg_we    = reg_we && !rst && (wa != 5'd0);
  assign dbg_waddr = wa;
  assign dbg_wdata = wd;

  p_pc_reset_r1: assert property (@(posedge clk) rst |=> pc == 32'd0);
  p_mem_excl_r5: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  p_beq_fall_r6: assert property (@(posedge clk) disable iff (rst)
                   (is_beq && rd1 != rd2) |=> pc == $past(pc) + 32'd4);
  p_jump_r7:     assert property (@(posedge clk) disable iff (rst)
                   is_j |=> (pc[1:0] == 2'b00 && pc[31:28] == $past(pc4[31:28])));
  p_r0_zero_r8:  assert property (@(posedge clk) disable iff (rst) rf[0] == 32'd0);
  p_nop_r9:      assert property (@(posedge clk) disable iff (rst)
                   illegal |=> (pc == $past(pc) + 32'd4 && $stable(rf[1])));
  p_nop_quiet_r9: assert property (@(posedge clk) disable iff (rst)
                   illegal |-> (!dbg_we && !mem_wr));
endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_en = 1'b0, ld_dmem = 1'b0;
  logic [7:0]  ld_addr = 8'd0;
  logic [31:0] ld_data = 32'd0;
  logic [31:0] dbg_pc, dbg_wdata;
  logic        dbg_we;
  logic [4:0]  dbg_waddr;

  int nchk = 0, nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_core u_dut (.clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
                 .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc),
                 .dbg_we(dbg_we), .dbg_waddr(dbg_waddr), .dbg_wdata(dbg_wdata));

  logic [31:0] prog [32];
  logic [31:0] mi [256];
  logic [31:0] md [256];
  logic [31:0] mr [32];
  logic [31:0] mpc;

  function automatic logic [31:0] rt_i(input int s, t, d, input logic [5:0] f);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, f};
  endfunction
  function automatic logic [31:0] im_i(input logic [5:0] o, input int s, t, input int imm);
    return {o, 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic dm, input int a, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = dm; ld_addr = 8'(a); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) prog[i] = 32'h2000_0000;
    prog[0]  = im_i(6'h23, 0, 1, 0);
    prog[1]  = im_i(6'h23, 0, 2, 4);
    prog[2]  = im_i(6'h23, 0, 3, 8);
    prog[3]  = rt_i(1, 2, 4, 6'h20);
    prog[4]  = rt_i(1, 2, 5, 6'h22);
    prog[5]  = rt_i(5, 1, 6, 6'h2A);
    prog[6]  = rt_i(1, 3, 7, 6'h2A);
    prog[7]  = rt_i(3, 2, 8, 6'h24);
    prog[8]  = rt_i(3, 2, 9, 6'h25);
    prog[9]  = rt_i(1, 2, 0, 6'h20);
    prog[10] = im_i(6'h2B, 3, 4, 16);
    prog[11] = im_i(6'h2B, 4, 9, -4);
    prog[12] = im_i(6'h23, 0, 10, 0);
    prog[13] = im_i(6'h23, 0, 11, 8);
    prog[14] = im_i(6'h04, 1, 2, 5);
    prog[15] = im_i(6'h04, 4, 10, 2);
    prog[16] = rt_i(1, 1, 12, 6'h20);
    prog[17] = rt_i(1, 1, 12, 6'h20);
    prog[18] = {6'h02, 26'd21};
    prog[19] = rt_i(1, 1, 13, 6'h20);
    prog[20] = rt_i(1, 1, 13, 6'h20);
    prog[21] = rt_i(1, 1, 1, 6'h20);
    prog[22] = 32'h2000_0000;
    prog[23] = rt_i(1, 1, 15, 6'h21);
    prog[24] = im_i(6'h2B, 0, 1, 12);
    prog[25] = im_i(6'h23, 0, 14, 12);
    prog[26] = im_i(6'h04, 0, 0, -1);

    for (int i = 0; i < 256; i++) begin mi[i] = 32'h2000_0000; md[i] = 32'd0; end
    for (int i = 0; i < 32; i++) begin mi[i] = prog[i]; mr[i] = 32'd0; end
    md[0] = 32'd5; md[1] = 32'd7; md[2] = 32'hFFFF_FFF0; md[3] = 32'h0F0F_00FF;

    repeat (2) @(negedge clk);
    for (int i = 0; i < 32; i++) load(1'b0, i, prog[i]);
    for (int i = 0; i < 4; i++)  load(1'b1, i, md[i]);
    #1;
    check("R1", "reset pc", dbg_pc, 32'd0);
    check("R1", "reset we", {31'd0, dbg_we}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    mpc = 32'd0;

    for (int cyc = 0; cyc < 60; cyc++) begin
      logic [31:0] ins, a, b, si, y, npc;
      logic [5:0]  o, f;
      logic [4:0]  s, t, d, wr;
      logic        we, wmem;
      string       tag;
      #1;
      ins = mi[mpc[9:2]];
      o = ins[31:26]; f = ins[5:0]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
      a = mr[s]; b = mr[t]; si = {{16{ins[15]}}, ins[15:0]};
      npc = mpc + 4; we = 1'b0; wmem = 1'b0; y = 32'd0; wr = 5'd0; tag = "R9";
      if (o == 6'h00 && (f == 6'h20 || f == 6'h22 || f == 6'h24 || f == 6'h25 || f == 6'h2A)) begin
        we = 1'b1; wr = d;
        tag = (d == 0) ? "R8" : ((s == d || t == d) ? "R3" : "R2");
        case (f)
          6'h20: y = a + b;
          6'h22: y = a - b;
          6'h24: y = a & b;
          6'h25: y = a | b;
          default: y = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        endcase
      end else if (o == 6'h23) begin
        we = 1'b1; wr = t; tag = "R4"; y = md[(a + si) >> 2 & 32'hFF];
      end else if (o == 6'h2B) begin
        wmem = 1'b1; tag = "R5";
      end else if (o == 6'h04) begin
        tag = "R6"; if (a == b) npc = mpc + 4 + (si << 2);
      end else if (o == 6'h02) begin
        tag = "R7"; npc = {npc[31:28], ins[25:0], 2'b00};
      end
      if (wr == 5'd0) we = 1'b0;
      check("R10", "pc", dbg_pc, mpc);
      check(tag, "write enable", {31'd0, dbg_we}, {31'd0, we});
      if (we) begin
        check(tag, "write addr", {27'd0, dbg_waddr}, {27'd0, wr});
        check(tag, "write data", dbg_wdata, y);
        mr[wr] = y;
      end
      if (wmem) md[(a + si) >> 2 & 32'hFF] = b;
      mpc = npc;
      @(negedge clk);
    end

    check("R2", "model r9 or", mr[9], 32'hFFFF_FFF7);
    check("R5", "model r10 reload", mr[10], 32'd12);
    check("R6", "model r12 skipped", mr[12], 32'd0);
    check("R7", "model r13 skipped", mr[13], 32'd0);
    check("R3", "model r14 doubled", mr[14], 32'd10);
    check("R10", "final pc loop", dbg_pc, 32'd104);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule